// File: doc/BRIEF.md
# Latched Serial-to-Parallel Column Driver

This block turns a slow serial bit stream into a wide parallel word for display column drivers. Each rising edge of an external shift clock moves one serial bit into a chain of stages. The shift clock is an ordinary input that is sampled by the fast system clock. A bank of holding registers copies the chain on every system cycle in which the load input is high, and keeps its value while that input is low. A gate then passes the held word to the channel outputs, or forces all of them low.

The end stage of the chain drives a serial cascade output, so several blocks can be chained one after another. A static direction input picks which end of the chain receives new data and which end feeds the cascade. The block has no level translation and no analog drive. Everything runs from one synchronous domain with a synchronous reset.

Top module: `sipo_column_driver`

## Requirements
- R1: A low-to-high change of `sclk_in` causes exactly one shift, however long the clock stays high. With the default `SYNC_STAGES`=2, the chain moves at the second system clock edge after the first edge that samples `sclk_in` high. It takes the `sdata_in` value that was sampled at that same first edge.
- R2: With `dir_rev`=0, the new bit enters stage 0 (`chan_out[0]`, channel 1). Each stage k passes its bit to stage k+1, and `cascade_out` equals the highest stage (bit 31 at the default width).
- R3: With `dir_rev`=1, the new bit enters the highest stage. Each stage k passes its bit to stage k-1, and `cascade_out` equals stage 0.
- R4: At every system edge where `latch_en` is high, the holding bank loads the chain contents that were present before that edge.
- R5: While `latch_en` is low, the holding bank keeps its value and the channel outputs do not change, even while shifting continues.
- R6: When `out_en`=0, every bit of `chan_out` is 0. When `out_en`=1, `chan_out` equals the held word.
- R7: Shifting and `cascade_out` do not depend on `latch_en` or `out_en`. The chain changes only in a cycle with a shift strobe.
- R8: A synchronous `rst` clears the chain, the holding bank and the synchronizer, so `chan_out` and `cascade_out` read 0 after reset.
- R9: Once at least CHANNELS bits have been shifted in one direction since reset, `cascade_out` equals the bit shifted CHANNELS strobes earlier.
- R10: A shift clock whose high and low levels each last two system cycles is still recognised on every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Shift clock from the host, sampled and edge-detected |
| sdata_in | input | 1 | Serial data, sampled together with sclk_in |
| latch_en | input | 1 | High: holding bank follows the chain every cycle |
| out_en | input | 1 | High: outputs show the held word; low: outputs forced low |
| dir_rev | input | 1 | Static direction: 0 forward, 1 reverse |
| chan_out | output | CHANNELS | Parallel channel outputs, bit 0 is channel 1 |
| cascade_out | output | 1 | Serial output for the next block in the chain |

## Verification
The bench builds the block with its defaults: 32 channels and a two-stage synchronizer. At these values, a 32-strobe cascade delay and a two-cycle minimum shift-clock pulse can both be checked in a few thousand cycles. A behavioural model advances on every clock and is compared with the outputs. The model reaches all of the following: forward and reverse word loading, load held high while the word moves, output gating toggled during a shift, a shift clock held high for a long time, and reset from a non-zero state.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   typedef enum logic {
      SHIFT_FWD = 1'b0,
      SHIFT_REV = 1'b1
   } shift_dir_e;

   localparam int MIN_CHANNELS    = 2;
   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/sipo_strobe_gen.sv
module sipo_strobe_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sclk_in,
   input  logic sdata_in,
   output logic strobe,
   output logic sdata_al
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] ck_pipe;
   logic [TOP:0] dt_pipe;
   logic         ck_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         ck_pipe <= '0;
         dt_pipe <= '0;
         ck_prev <= 1'b0;
      end else begin
         ck_pipe <= {ck_pipe[TOP-1:0], sclk_in};
         dt_pipe <= {dt_pipe[TOP-1:0], sdata_in};
         ck_prev <= ck_pipe[TOP];
      end
   end

   assign strobe   = ck_pipe[TOP] & ~ck_prev;
   assign sdata_al = dt_pipe[TOP];
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
   import sipo_pkg::*;
#(
   parameter int CHANNELS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                strobe,
   input  logic                din,
   input  logic                dir_rev,
   output logic [CHANNELS-1:0] chain_q,
   output logic                cascade
);
   localparam int LAST = CHANNELS - 1;

   shift_dir_e dir;
   assign dir = shift_dir_e'(dir_rev);

   for (genvar g = 0; g < CHANNELS; g++) begin : g_stage
      logic fwd_src;
      logic rev_src;
      if (g == 0) begin : g_fwd_head
         assign fwd_src = din;
      end else begin : g_fwd_mid
         assign fwd_src = chain_q[g-1];
      end
      if (g == LAST) begin : g_rev_head
         assign rev_src = din;
      end else begin : g_rev_mid
         assign rev_src = chain_q[g+1];
      end
      always_ff @(posedge clk) begin
         if (rst)
            chain_q[g] <= 1'b0;
         else if (strobe)
            chain_q[g] <= (dir == SHIFT_REV) ? rev_src : fwd_src;
      end
   end

   assign cascade = (dir == SHIFT_REV) ? chain_q[0] : chain_q[LAST];
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
   parameter int CHANNELS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [CHANNELS-1:0] d,
   output logic [CHANNELS-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/sipo_column_driver.sv
module sipo_column_driver
   import sipo_pkg::*;
#(
   parameter int CHANNELS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sclk_in,
   input  logic                sdata_in,
   input  logic                latch_en,
   input  logic                out_en,
   input  logic                dir_rev,
   output logic [CHANNELS-1:0] chan_out,
   output logic                cascade_out
);
   if (CHANNELS < MIN_CHANNELS) begin : g_bad_channels
      $error("sipo_column_driver: CHANNELS below minimum");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("sipo_column_driver: SYNC_STAGES below minimum");
   end

   logic                strobe;
   logic                sdata_al;
   logic [CHANNELS-1:0] chain_q;
   logic [CHANNELS-1:0] lat_q;

   sipo_strobe_gen #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk      (clk),
      .rst      (rst),
      .sclk_in  (sclk_in),
      .sdata_in (sdata_in),
      .strobe   (strobe),
      .sdata_al (sdata_al)
   );

   sipo_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .din     (sdata_al),
      .dir_rev (dir_rev),
      .chain_q (chain_q),
      .cascade (cascade_out)
   );

   sipo_latch_bank #(.CHANNELS(CHANNELS)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .load (latch_en),
      .d    (chain_q),
      .q    (lat_q)
   );

   assign chan_out = out_en ? lat_q : '0;
endmodule

// File: rtl/sipo_column_driver_chk.sv
module sipo_column_driver_chk #(
   parameter int CHANNELS = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                latch_en,
   input logic                out_en,
   input logic                dir_rev,
   input logic                strobe,
   input logic [CHANNELS-1:0] chain_q,
   input logic [CHANNELS-1:0] lat_q,
   input logic [CHANNELS-1:0] chan_out,
   input logic                cascade_out
);
   // R1: a strobe never lasts two cycles
   a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   // R7: the chain only moves on a strobe
   a_r7_chain_still: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(chain_q));

   a_r2_cascade_fwd: assert property (@(posedge clk) disable iff (rst)
      !dir_rev |-> cascade_out == chain_q[CHANNELS-1]);

   a_r3_cascade_rev: assert property (@(posedge clk) disable iff (rst)
      dir_rev |-> cascade_out == chain_q[0]);

   a_r4_latch_loads: assert property (@(posedge clk) disable iff (rst)
      latch_en |=> lat_q == $past(chain_q));

   a_r5_latch_holds: assert property (@(posedge clk) disable iff (rst)
      !latch_en |=> $stable(lat_q));

   a_r6_gate_low: assert property (@(posedge clk) disable iff (rst)
      !out_en |-> chan_out == '0);

   a_r6_gate_pass: assert property (@(posedge clk) disable iff (rst)
      out_en |-> chan_out == lat_q);
endmodule

bind sipo_column_driver sipo_column_driver_chk #(.CHANNELS(CHANNELS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .latch_en    (latch_en),
   .out_en      (out_en),
   .dir_rev     (dir_rev),
   .strobe      (strobe),
   .chain_q     (chain_q),
   .lat_q       (lat_q),
   .chan_out    (chan_out),
   .cascade_out (cascade_out)
);

// File: tb/sim_sipo_column_driver.sv
`timescale 1ns/1ps
module sim_sipo_column_driver;
   localparam int N    = 32;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sclk_in = 1'b0;
   logic         sdata_in = 1'b0;
   logic         latch_en = 1'b0;
   logic         out_en = 1'b0;
   logic         dir_rev = 1'b0;
   logic [N-1:0] chan_out;
   logic         cascade_out;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sipo_column_driver #(.CHANNELS(N), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
      .latch_en(latch_en), .out_en(out_en), .dir_rev(dir_rev),
      .chan_out(chan_out), .cascade_out(cascade_out)
   );

   // behavioural reference model
   logic [N-1:0] m_chain = '0;
   logic [N-1:0] m_lat   = '0;
   bit           ck_h[$];
   bit           dt_h[$];
   bit           sent[$];

   task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit stb;
      bit d;
      if (rst) begin
         m_chain = '0;
         m_lat   = '0;
         ck_h.delete();
         dt_h.delete();
         sent.delete();
         for (int i = 0; i <= SYNC; i++) begin
            ck_h.push_back(1'b0);
            dt_h.push_back(1'b0);
         end
      end else begin
         stb = ck_h[SYNC-1] && !ck_h[SYNC];
         d   = dt_h[SYNC-1];
         if (latch_en) m_lat = m_chain;
         if (stb) begin
            if (dir_rev) m_chain = {d, m_chain[N-1:1]};
            else         m_chain = {m_chain[N-2:0], d};
            sent.push_back(d);
         end
         ck_h.push_front(sclk_in);
         dt_h.push_front(sdata_in);
         void'(ck_h.pop_back());
         void'(dt_h.pop_back());
      end
      #2;
      if (!rst && !finished) begin
         chk(chan_out, out_en ? m_lat : '0, "R1 R4 R5 R6 channels");
         chk({{(N-1){1'b0}}, cascade_out},
             {{(N-1){1'b0}}, dir_rev ? m_chain[0] : m_chain[N-1]}, "R2 R3 R7 cascade");
         if (sent.size() >= N)
            chk({{(N-1){1'b0}}, cascade_out},
                {{(N-1){1'b0}}, sent[sent.size()-N]}, "R9 cascade delay");
      end
   end

   task automatic shift_bit(input bit b, input int hi, input int lo);
      @(negedge clk);
      sdata_in = b;
      sclk_in  = 1'b1;
      repeat (hi) @(negedge clk);
      sclk_in = 1'b0;
      repeat (lo - 1) @(negedge clk);
   endtask

   // forward sends MSB first, reverse sends LSB first: both leave chain == p
   task automatic shift_word(input logic [N-1:0] p, input int hi, input int lo);
      for (int i = 0; i < N; i++)
         shift_bit(dir_rev ? p[i] : p[N-1-i], hi, lo);
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic pulse_latch();
      @(negedge clk);
      latch_en = 1'b1;
      @(negedge clk);
      latch_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [N-1:0] pa = 32'hA5C3_0F96;
      logic [N-1:0] pb = 32'h1248_FEDC;
      logic [N-1:0] pc = 32'h7E81_3C5A;
      logic [N-1:0] pd = 32'h0000_8001;
      logic [N-1:0] pe = 32'hCAFE_1357;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      out_en = 1'b1;
      @(negedge clk);
      chk(chan_out, '0, "R8 reset channels");
      chk({{(N-1){1'b0}}, cascade_out}, '0, "R8 reset cascade");

      shift_word(pa, 3, 3);
      chk(chan_out, '0, "R5 hold while shifting");
      pulse_latch();
      chk(chan_out, pa, "R2 R4 forward word");
      out_en = 1'b0;
      @(negedge clk);
      chk(chan_out, '0, "R6 gate low");
      out_en = 1'b1;
      @(negedge clk);
      chk(chan_out, pa, "R6 gate pass");

      // R7: toggle enables while the next word moves
      fork
         shift_word(pb, 3, 3);
         begin
            repeat (40) @(negedge clk);
            out_en = 1'b0;
            repeat (30) @(negedge clk);
            out_en = 1'b1;
         end
      join
      chk(chan_out, pa, "R5 R7 held word");
      pulse_latch();
      chk(chan_out, pb, "R4 R9 second word");

      // R10: minimum-width shift clock with load held high
      latch_en = 1'b1;
      shift_word(pc, 2, 2);
      chk(chan_out, pc, "R4 R10 tracking load");
      latch_en = 1'b0;

      // R1: long high level gives one shift per edge
      shift_word(pe, 12, 3);
      pulse_latch();
      chk(chan_out, pe, "R1 long high");

      do_reset();
      chk(chan_out, '0, "R8 reset from data");
      chk({{(N-1){1'b0}}, cascade_out}, '0, "R8 cascade cleared");

      dir_rev = 1'b1;
      shift_word(pd, 3, 3);
      pulse_latch();
      chk(chan_out, pd, "R3 reverse word");
      shift_word(pa, 3, 3);
      pulse_latch();
      chk(chan_out, pa, "R3 R9 reverse second word");

      finished = 1;
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule